// File: doc/BRIEF.md
# Word-Serial AES Block Cipher Engine

This block encrypts or decrypts one 128-bit block with AES. Its datapath is one 32-bit state column wide. Each clock cycle it produces one column of the next state, so every round takes four cycles. The initial key addition takes four cycles as well. The total is 44, 52 or 60 cycles for 128-, 192- and 256-bit keys.

A block, a two-bit key-size code and a direction flag are handed over through a valid/ready handshake. The engine does not expand keys. It reads the already expanded schedule one 32-bit word at a time from an external store, through a word-index output and a data input. The store must return the data one cycle after the index. When decrypting, the engine walks the schedule from its last round key back to its first.

The substitution boxes are built from GF(2^8) inversion plus the affine maps, not from lookup tables. The result is held on `out_data` and flagged with a one-cycle `done` pulse.

Top module: `aes_ws_core`

## Requirements
- R1: While reset is applied and after it is released, `in_ready` is 1 and `done` is 0.
- R2: With `in_ksize`=00 and `in_decrypt`=0, the engine runs 10 rounds and returns the standard AES-128 ciphertext. Byte 0 of a block sits in bits 127:120. State column c is bits [127-32c -: 32], with row 0 in its top byte. Round-key word i of the schedule uses the same byte order.
- R3: With `in_ksize`=01 the engine runs 12 rounds, and with `in_ksize`=10 it runs 14 rounds. In both cases it returns the standard AES-192 and AES-256 ciphertexts.
- R4: With `in_decrypt`=1 the engine applies the inverse cipher, turning the standard ciphertexts back into plaintext for all three key sizes.
- R5: `done` rises exactly 4·(Nr+1) cycles after the clock edge that accepts a block, where Nr is the round count.
- R6: `in_ready` falls at the accepting edge, stays 0 while the block is processed, and returns to 1 in the same cycle that `done` is 1.
- R7: `done` is high for a single cycle. `out_data` keeps its value from that cycle until the next block is accepted.
- R8: `rk_addr` leads its use by one cycle. In the accepting cycle it holds 0 when encrypting and 4·Nr when decrypting. While step k runs (j=k/4, c=k%4, up to the last step) it holds the index for step k+1. That index is 4j+c when encrypting and 4(Nr−j)+c when decrypting.
- R9: Decrypting the engine's own ciphertext of an arbitrary block under the same key restores that block.
- R10: While a block is in progress, `in_valid`, `in_data`, `in_ksize` and `in_decrypt` have no effect on the result or on the index sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A block is offered |
| in_ready | output | 1 | Engine is idle and will take a block |
| in_data | input | 128 | Plaintext or ciphertext block |
| in_ksize | input | 2 | Key size: 00 = 128, 01 = 192, 10 = 256 bits |
| in_decrypt | input | 1 | 1 = decrypt, 0 = encrypt |
| rk_addr | output | 6 | Index of the round-key word to read |
| rk_data | input | 32 | Round-key word, valid one cycle after its index |
| done | output | 1 | One-cycle pulse: result available |
| out_data | output | 128 | Result block |

## Verification
The published test vectors for all three key sizes are run in both directions. Encryption results separate a correct round count and forward ShiftRows byte selection from off-by-one or mirrored variants. Decryption results expose errors in the reversed key-group walk and in the order of the inverse steps. A round trip on an unrelated plaintext under the 192-bit key shows that the forward and inverse paths are true inverses away from the published data. A run in which the inputs are toggled with garbage during processing, with the per-cycle index sequence checked throughout, separates a correctly latched request from one that follows its live inputs.

// File: rtl/aes_ws_pkg.sv
package aes_ws_pkg;

  localparam int BLOCK_W  = 128;
  localparam int COL_W    = 32;
  localparam int BYTE_W   = 8;
  localparam int NCOL     = BLOCK_W / COL_W;
  localparam int NBYTE    = BLOCK_W / BYTE_W;
  localparam int MAX_NR   = 14;
  localparam int RND_W    = $clog2(MAX_NR + 1);
  localparam int COLIDX_W = $clog2(NCOL);
  localparam int KADDR_W  = RND_W + COLIDX_W;

  typedef enum logic [1:0] {
    KSZ_128  = 2'b00,
    KSZ_192  = 2'b01,
    KSZ_256  = 2'b10,
    KSZ_RSVD = 2'b11
  } ksize_e;

  function automatic logic [RND_W-1:0] rounds_for(input logic [1:0] code);
    case (ksize_e'(code))
      KSZ_128: return RND_W'(10);
      KSZ_192: return RND_W'(12);
      default: return RND_W'(14);
    endcase
  endfunction

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = xtime(sh);
    end
    return acc;
  endfunction

  function automatic logic [31:0] mix_col(input logic [31:0] w);
    logic [7:0] a0, a1, a2, a3;
    {a0, a1, a2, a3} = w;
    return {xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3,
            a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3,
            a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3,
            xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3)};
  endfunction

  function automatic logic [31:0] inv_mix_col(input logic [31:0] w);
    logic [7:0] a0, a1, a2, a3;
    {a0, a1, a2, a3} = w;
    return {gf_mul(a0, 8'd14) ^ gf_mul(a1, 8'd11) ^ gf_mul(a2, 8'd13) ^ gf_mul(a3, 8'd9),
            gf_mul(a0, 8'd9)  ^ gf_mul(a1, 8'd14) ^ gf_mul(a2, 8'd11) ^ gf_mul(a3, 8'd13),
            gf_mul(a0, 8'd13) ^ gf_mul(a1, 8'd9)  ^ gf_mul(a2, 8'd14) ^ gf_mul(a3, 8'd11),
            gf_mul(a0, 8'd11) ^ gf_mul(a1, 8'd13) ^ gf_mul(a2, 8'd9)  ^ gf_mul(a3, 8'd14)};
  endfunction

endpackage

// File: rtl/aes_ws_sbox.sv
module aes_ws_sbox (
  input  logic [7:0] byte_i,
  input  logic       inverse_i,
  output logic [7:0] byte_o
);
  import aes_ws_pkg::*;

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  logic [7:0] pre;
  logic [7:0] sq;
  logic [7:0] inv;

  // Multiplicative inverse as x^254 = product of x^2 .. x^128
  always_comb begin
    pre = inverse_i ? (rotl8(byte_i, 1) ^ rotl8(byte_i, 3) ^ rotl8(byte_i, 6) ^ 8'h05)
                    : byte_i;
    sq  = pre;
    inv = 8'h01;
    for (int i = 1; i < 8; i++) begin
      sq  = gf_mul(sq, sq);
      inv = gf_mul(inv, sq);
    end
    byte_o = inverse_i ? inv
                       : (inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3) ^ rotl8(inv, 4) ^ 8'h63);
  end

endmodule

// File: rtl/aes_ws_colpath.sv
module aes_ws_colpath
  import aes_ws_pkg::*;
(
  input  logic [BLOCK_W-1:0]  state_i,
  input  logic [COLIDX_W-1:0] col_i,
  input  logic                decrypt_i,
  input  logic                addkey_only_i,
  input  logic                skip_mix_i,
  input  logic [COL_W-1:0]    rk_i,
  output logic [COL_W-1:0]    col_o
);

  logic [BYTE_W-1:0] st_bytes [NBYTE];
  logic [COL_W-1:0]  own_word;
  logic [COL_W-1:0]  sub_word;
  logic [COL_W-1:0]  keyed;

  for (genvar b = 0; b < NBYTE; b++) begin : g_unpack
    assign st_bytes[b] = state_i[BLOCK_W-1-BYTE_W*b -: BYTE_W];
  end

  // One S-box per row; the row shift is a choice of source column
  for (genvar r = 0; r < NCOL; r++) begin : g_row
    logic [COLIDX_W-1:0] src;
    logic [BYTE_W-1:0]   sb;
    assign src = decrypt_i ? col_i - COLIDX_W'(r) : col_i + COLIDX_W'(r);
    aes_ws_sbox u_sbox (
      .byte_i   (st_bytes[{src, COLIDX_W'(r)}]),
      .inverse_i(decrypt_i),
      .byte_o   (sb)
    );
    assign sub_word[COL_W-1-BYTE_W*r -: BYTE_W] = sb;
    assign own_word[COL_W-1-BYTE_W*r -: BYTE_W] = st_bytes[{col_i, COLIDX_W'(r)}];
  end

  always_comb begin
    keyed = sub_word ^ rk_i;
    if (addkey_only_i) begin
      col_o = own_word ^ rk_i;
    end else if (!decrypt_i) begin
      col_o = (skip_mix_i ? sub_word : mix_col(sub_word)) ^ rk_i;
    end else begin
      col_o = skip_mix_i ? keyed : inv_mix_col(keyed);
    end
  end

endmodule

// File: rtl/aes_ws_seq.sv
module aes_ws_seq
  import aes_ws_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [1:0]          ksize_i,
  input  logic                decrypt_i,
  output logic                busy_o,
  output logic [COLIDX_W-1:0] col_o,
  output logic                first_rnd_o,
  output logic                last_rnd_o,
  output logic                decrypt_o,
  output logic [KADDR_W-1:0]  rk_addr_o,
  output logic                done_o
);

  localparam logic [COLIDX_W-1:0] LAST_COL = COLIDX_W'(NCOL - 1);

  logic                busy_q, busy_d;
  logic [COLIDX_W-1:0] col_q, col_d, col_nx;
  logic [RND_W-1:0]    rnd_q, rnd_d, rnd_nx;
  logic [RND_W-1:0]    nr_q, nr_d;
  logic                dec_q, dec_d;
  logic                done_q, done_d;
  logic                last_step;
  logic                ctl_en;

  function automatic logic [KADDR_W-1:0] key_index(input logic [RND_W-1:0] rnd,
                                                   input logic [RND_W-1:0] nr,
                                                   input logic [COLIDX_W-1:0] col,
                                                   input logic dec);
    logic [RND_W-1:0] grp;
    grp = dec ? nr - rnd : rnd;
    return {grp, col};
  endfunction

  always_comb begin
    last_step = busy_q && (col_q == LAST_COL) && (rnd_q == nr_q);
    col_nx    = col_q + 1'b1;
    rnd_nx    = (col_q == LAST_COL) ? rnd_q + 1'b1 : rnd_q;
    busy_d    = busy_q;
    col_d     = col_q;
    rnd_d     = rnd_q;
    nr_d      = nr_q;
    dec_d     = dec_q;
    done_d    = 1'b0;
    if (!busy_q) begin
      if (start_i) begin
        busy_d = 1'b1;
        col_d  = '0;
        rnd_d  = '0;
        nr_d   = rounds_for(ksize_i);
        dec_d  = decrypt_i;
      end
    end else if (last_step) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end else begin
      col_d = col_nx;
      rnd_d = rnd_nx;
    end
    // Index for the word consumed in the following cycle
    if (!busy_q)        rk_addr_o = key_index('0, rounds_for(ksize_i), '0, decrypt_i);
    else if (last_step) rk_addr_o = key_index(rnd_q, nr_q, col_q, dec_q);
    else                rk_addr_o = key_index(rnd_nx, nr_q, col_nx, dec_q);
  end

  assign ctl_en = start_i | busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      col_q  <= '0;
      rnd_q  <= '0;
      nr_q   <= '0;
      dec_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (ctl_en) begin
        busy_q <= busy_d;
        col_q  <= col_d;
        rnd_q  <= rnd_d;
        nr_q   <= nr_d;
        dec_q  <= dec_d;
      end
    end
  end

  assign busy_o      = busy_q;
  assign col_o       = col_q;
  assign first_rnd_o = (rnd_q == '0);
  assign last_rnd_o  = (rnd_q == nr_q);
  assign decrypt_o   = dec_q;
  assign done_o      = done_q;

endmodule

// File: rtl/aes_ws_core.sv
module aes_ws_core
  import aes_ws_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [BLOCK_W-1:0] in_data,
  input  logic [1:0]         in_ksize,
  input  logic               in_decrypt,
  output logic [KADDR_W-1:0] rk_addr,
  input  logic [COL_W-1:0]   rk_data,
  output logic               done,
  output logic [BLOCK_W-1:0] out_data
);

  localparam logic [COLIDX_W-1:0] LAST_COL = COLIDX_W'(NCOL - 1);

  logic [1:0]                      rst_pipe;
  logic                            rst_int_n;
  logic                            accept;
  logic                            busy;
  logic [COLIDX_W-1:0]             col;
  logic                            first_rnd;
  logic                            last_rnd;
  logic                            dec;
  logic [COL_W-1:0]                col_word;
  logic [BLOCK_W-1:0]              cur_q, cur_d;
  logic [NCOL-2:0][COL_W-1:0]      nxt_q, nxt_d;
  logic                            cur_en;
  logic                            nxt_en;

  // Reset asserts at once, leaves after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  aes_ws_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_i    (accept),
    .ksize_i    (in_ksize),
    .decrypt_i  (in_decrypt),
    .busy_o     (busy),
    .col_o      (col),
    .first_rnd_o(first_rnd),
    .last_rnd_o (last_rnd),
    .decrypt_o  (dec),
    .rk_addr_o  (rk_addr),
    .done_o     (done)
  );

  aes_ws_colpath u_col (
    .state_i      (cur_q),
    .col_i        (col),
    .decrypt_i    (dec),
    .addkey_only_i(first_rnd),
    .skip_mix_i   (last_rnd),
    .rk_i         (rk_data),
    .col_o        (col_word)
  );

  // Columns 0..2 wait in nxt; the fourth completes the round
  always_comb begin
    cur_d = cur_q;
    nxt_d = nxt_q;
    if (accept) begin
      cur_d = in_data;
    end else if (busy) begin
      if (col == LAST_COL) begin
        for (int i = 0; i < NCOL - 1; i++) begin
          cur_d[BLOCK_W-1-COL_W*i -: COL_W] = nxt_q[i];
        end
        cur_d[COL_W-1:0] = col_word;
      end else begin
        for (int i = 0; i < NCOL - 1; i++) begin
          if (col == COLIDX_W'(i)) nxt_d[i] = col_word;
        end
      end
    end
  end

  assign cur_en = accept || (busy && (col == LAST_COL));
  assign nxt_en = busy && (col != LAST_COL);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cur_q <= '0;
      nxt_q <= '0;
    end else begin
      if (cur_en) cur_q <= cur_d;
      if (nxt_en) nxt_q <= nxt_d;
    end
  end

  assign out_data = cur_q;

endmodule

// File: rtl/aes_ws_chk.sv
module aes_ws_chk
  import aes_ws_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [BLOCK_W-1:0] in_data,
  input logic [1:0]         in_ksize,
  input logic               in_decrypt,
  input logic [KADDR_W-1:0] rk_addr,
  input logic [COL_W-1:0]   rk_data,
  input logic               done,
  input logic [BLOCK_W-1:0] out_data
);

  logic [KADDR_W:0] lat_cnt;
  logic [KADDR_W:0] lat_exp;
  logic             armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_cnt <= '0;
      lat_exp <= '0;
      armed   <= 1'b0;
    end else if (in_valid && in_ready) begin
      lat_cnt <= '0;
      armed   <= 1'b1;
      case (in_ksize)
        2'b00:   lat_exp <= (KADDR_W+1)'(44);
        2'b01:   lat_exp <= (KADDR_W+1)'(52);
        default: lat_exp <= (KADDR_W+1)'(60);
      endcase
    end else if (!in_ready) begin
      lat_cnt <= lat_cnt + 1'b1;
    end
  end

  AST_START_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R6

  AST_READY_BACK_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> done); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> $stable(out_data)); // R7

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (armed && lat_cnt == lat_exp)); // R5

  AST_KEY_INDEX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> ({1'b0, rk_addr} < lat_exp)); // R8

  AST_ENC_FIRST_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_decrypt) |-> (rk_addr == '0)); // R8

endmodule

bind aes_ws_core aes_ws_chk u_chk (.*);

// File: tb/aes_ws_core_test.sv
`timescale 1ns/1ps
module aes_ws_core_test;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [127:0] in_data;
  logic [1:0]   in_ksize;
  logic         in_decrypt;
  logic [5:0]   rk_addr;
  logic [31:0]  rk_data;
  logic         done;
  logic [127:0] out_data;

  int tests = 0;
  int fails = 0;

  logic [31:0] ks_mem [64];
  logic [7:0]  sb [256];

  localparam logic [127:0] PT   = 128'h00112233445566778899aabbccddeeff;
  localparam logic [255:0] K128 = {128'h000102030405060708090a0b0c0d0e0f, 128'h0};
  localparam logic [255:0] K192 = {192'h000102030405060708090a0b0c0d0e0f1011121314151617, 64'h0};
  localparam logic [255:0] K256 = 256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f;
  localparam logic [127:0] CT128 = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] CT192 = 128'hdda97ca4864cdfe06eaf70a0ec0d7191;
  localparam logic [127:0] CT256 = 128'h8ea2b7ca516745bfeafc49904b496089;

  aes_ws_core uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_ksize  (in_ksize),
    .in_decrypt(in_decrypt),
    .rk_addr   (rk_addr),
    .rk_data   (rk_data),
    .done      (done),
    .out_data  (out_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Expanded-key store, one cycle read latency
  always @(posedge clk) rk_data <= ks_mem[rk_addr];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rl(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  // S-box from the generator walk: p steps by 3, q by its inverse
  task automatic build_sbox();
    logic [7:0] p, q, x;
    p = 8'h01;
    q = 8'h01;
    do begin
      p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b0};
      q = q ^ {q[3:0], 4'b0};
      if (q[7]) q = q ^ 8'h09;
      x = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4);
      sb[p] = x ^ 8'h63;
    end while (p != 8'h01);
    sb[0] = 8'h63;
  endtask

  function automatic logic [31:0] subw(input logic [31:0] w);
    return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
  endfunction

  task automatic expand_key(input logic [255:0] key, input int nk);
    logic [31:0] tmp;
    logic [7:0]  rc;
    int          total;
    total = 4 * (nk + 7);
    rc = 8'h01;
    for (int i = 0; i < 64; i++) ks_mem[i] = 32'h0;
    for (int i = 0; i < total; i++) begin
      if (i < nk) begin
        ks_mem[i] = key[255-32*i -: 32];
      end else begin
        tmp = ks_mem[i-1];
        if (i % nk == 0) begin
          tmp = subw({tmp[23:0], tmp[31:24]}) ^ {rc, 24'h0};
          rc  = {rc[6:0], 1'b0} ^ (rc[7] ? 8'h1b : 8'h00);
        end else if (nk > 6 && i % nk == 4) begin
          tmp = subw(tmp);
        end
        ks_mem[i] = ks_mem[i-nk] ^ tmp;
      end
    end
  endtask

  // Handshake, per-cycle protocol checks (R5 R6 R7 R8 R10), returns result
  task automatic run_block(input logic [127:0] din, input logic [1:0] ks, input bit dec,
                           input bit junk, input string tag, output logic [127:0] dout);
    int nr, n, ea;
    bit busy_ok, addr_ok;
    logic [5:0] bad_addr;
    nr = (ks == 2'b00) ? 10 : (ks == 2'b01) ? 12 : 14;
    n  = 4 * (nr + 1);
    busy_ok = 1'b1;
    addr_ok = 1'b1;
    bad_addr = '0;
    @(negedge clk);
    in_data = din; in_ksize = ks; in_decrypt = dec; in_valid = 1'b1;
    #1;
    ea = dec ? 4 * nr : 0;
    chk(in_ready == 1'b1 && rk_addr == 6'(ea), "R8", {tag, " first index / ready"},
        {120'h0, in_ready, 1'b0, rk_addr}, {120'h0, 1'b1, 1'b0, 6'(ea)});
    @(posedge clk);
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      #1;
      if (in_ready !== 1'b0 || done !== 1'b0) busy_ok = 1'b0;
      if (i < n) begin
        ea = dec ? 4 * (nr - i / 4) + i % 4 : i;
        if (rk_addr !== 6'(ea) && addr_ok) begin
          addr_ok = 1'b0;
          bad_addr = rk_addr;
          $display("  index mismatch at step %0d: %0d vs %0d", i, rk_addr, ea);
        end
      end
      if (junk && i < n) begin
        in_valid = 1'b1; in_data = ~din; in_ksize = ~ks; in_decrypt = ~dec;
      end else begin
        in_valid = 1'b0;
      end
    end
    chk(busy_ok, "R6", {tag, " ready low, no done while busy"}, {127'h0, busy_ok}, 128'h1);
    chk(addr_ok, "R8", {tag, " round-key index sequence"}, {122'h0, bad_addr}, 128'h0);
    @(negedge clk);
    #1;
    chk(done == 1'b1 && in_ready == 1'b1, "R5", {tag, " done and ready after 4(Nr+1) cycles"},
        {126'h0, done, in_ready}, 128'h3);
    dout = out_data;
    @(negedge clk);
    #1;
    chk(done == 1'b0, "R7", {tag, " done lasts one cycle"}, {127'h0, done}, 128'h0);
    repeat (2) @(negedge clk);
    #1;
    chk(out_data == dout, "R7", {tag, " result held"}, out_data, dout);
  endtask

  task automatic t_reset();
    chk(in_ready == 1'b1 && done == 1'b0, "R1", "ready=1 done=0 after reset",
        {126'h0, in_ready, done}, 128'h2);
  endtask

  task automatic t_enc_128();
    logic [127:0] r;
    expand_key(K128, 4);
    run_block(PT, 2'b00, 1'b0, 1'b0, "enc128", r);
    chk(r == CT128, "R2", "AES-128 ciphertext", r, CT128);
  endtask

  task automatic t_enc_192_256();
    logic [127:0] r;
    expand_key(K192, 6);
    run_block(PT, 2'b01, 1'b0, 1'b0, "enc192", r);
    chk(r == CT192, "R3", "AES-192 ciphertext", r, CT192);
    expand_key(K256, 8);
    run_block(PT, 2'b10, 1'b0, 1'b0, "enc256", r);
    chk(r == CT256, "R3", "AES-256 ciphertext", r, CT256);
  endtask

  task automatic t_dec_all();
    logic [127:0] r;
    expand_key(K128, 4);
    run_block(CT128, 2'b00, 1'b1, 1'b0, "dec128", r);
    chk(r == PT, "R4", "AES-128 decrypt", r, PT);
    expand_key(K192, 6);
    run_block(CT192, 2'b01, 1'b1, 1'b0, "dec192", r);
    chk(r == PT, "R4", "AES-192 decrypt", r, PT);
    expand_key(K256, 8);
    run_block(CT256, 2'b10, 1'b1, 1'b0, "dec256", r);
    chk(r == PT, "R4", "AES-256 decrypt", r, PT);
  endtask

  task automatic t_roundtrip();
    logic [127:0] c, r;
    logic [127:0] blk;
    blk = 128'h3243f6a8885a308d313198a2e0370734;
    expand_key(K192, 6);
    run_block(blk, 2'b01, 1'b0, 1'b0, "rt-enc", c);
    chk(c != blk, "R9", "ciphertext differs from input", c, blk);
    run_block(c, 2'b01, 1'b1, 1'b0, "rt-dec", r);
    chk(r == blk, "R9", "decrypt(encrypt(x)) == x", r, blk);
  endtask

  task automatic t_ignore_busy();
    logic [127:0] r;
    expand_key(K256, 8);
    run_block(CT256, 2'b10, 1'b1, 1'b1, "junk-dec256", r);
    chk(r == PT, "R10", "inputs toggled while busy ignored", r, PT);
    expand_key(K128, 4);
    run_block(PT, 2'b00, 1'b0, 1'b1, "junk-enc128", r);
    chk(r == CT128, "R10", "inputs toggled while busy ignored", r, CT128);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    in_ksize = 2'b00;
    in_decrypt = 1'b0;
    build_sbox();
    for (int i = 0; i < 64; i++) ks_mem[i] = 32'h0;
    repeat (4) @(negedge clk);
    #1;
    chk(in_ready == 1'b1 && done == 1'b0, "R1", "ready=1 done=0 during reset",
        {126'h0, in_ready, done}, 128'h2);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    t_reset();
    t_enc_128();
    t_enc_192_256();
    t_dec_all();
    t_roundtrip();
    t_ignore_busy();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule